// File: doc/BRIEF.md
# Receive descriptor ring writer

This block stores incoming frames into memory buffers described by a ring of two-word descriptors. Each descriptor has an address word and a status word. In the address word, bits [31:2] give a word-aligned buffer address, bit 1 marks the last descriptor of the ring, and bit 0 is the ownership flag. A frame comes in as a byte stream with start and end markers. The block fetches the descriptor at its current ring position and checks that the engine may still fill it. It then writes the bytes into the buffer one byte lane at a time. Last, it writes the status word and only after that sets the ownership flag.

A frame larger than one buffer carries on into the following descriptors. The first of them is marked start-of-frame, the last is marked end-of-frame, and the last also holds the total length. If a descriptor the block wants is already owned, the rest of the frame is thrown away and a one-cycle no-buffer flag is raised. The ring position then stays on that descriptor, so the next frame waits for software to free it. The size of each buffer is given in 64-byte units. The 4-byte check sequence can be left out of the recorded length.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: On a start byte, the block reads the address word at the current ring position, with the read data valid one cycle later. If bit 0 of that word is 0, byte k of the buffer is written to byte address ({word[31:2],2'b00} + k), with exactly one byte-enable bit set, lane = address[1:0].
- R2: While rx_enable is low, the stream is not accepted (s_ready low) and nothing is written to memory. The first enabled idle cycle loads the ring position from ring_base, which is 8-byte aligned.
- R3: The status word is written with all byte enables at ring position + 4. Bits [13:0] hold the length, bit 14 is start-of-frame, bit 15 is end-of-frame, and bits [31:16] are zero.
- R4: In the cycle after the status write, the address word is written back with the same bits [31:1] and bit 0 set to 1.
- R5: After the ownership write, the ring position moves forward by 8 bytes. If bit 1 of the address word was set, it returns to the loaded ring base instead.
- R6: If the fetched address word has bit 0 set at the start of a frame, the whole frame is consumed without any memory write. nobuf pulses for one cycle and the ring position does not move.
- R7: The buffer limit is buf_units×64 bytes, and a buf_units value of 0 is treated as 1. A frame exactly as long as the limit uses a single descriptor, which carries both start and end flags.
- R8: A frame longer than the limit continues into the following descriptors. Only the first carries start-of-frame and only the last carries end-of-frame. Each earlier descriptor records the limit as its length, and the last records the total frame length.
- R9: With strip_fcs high, the length recorded in the last descriptor is the total minus 4, with a floor of 0. All bytes are still stored.
- R10: In idle, a byte presented without the start marker is accepted and discarded, with no memory write.
- R11: If a follow-on descriptor is owned in the middle of a frame, the rest of the frame is dropped and nobuf pulses. The descriptors already filled stay handed over without end-of-frame, and the ring position stays on the owned descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Reception enable; when it rises, the ring position is loaded from ring_base |
| ring_base | input | 32 | Byte address of the first descriptor (8-byte aligned) |
| buf_units | input | 8 | Buffer size per descriptor in 64-byte units |
| strip_fcs | input | 1 | Record the length without the trailing 4 bytes |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | First byte of a frame |
| s_eof | input | 1 | Last byte of a frame |
| s_ready | output | 1 | Stream byte accepted at this edge when s_valid is also high |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address (word-aligned for full-word accesses) |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| nobuf | output | 1 | One-cycle pulse when a frame is dropped for lack of a free descriptor |

## Verification
The assertions assume that ring_base is 8-byte aligned and that buf_units and strip_fcs stay stable while a frame is in progress. They also assume the memory returns read data exactly one cycle after a read and that stream frames end with an end marker. The stimulus keeps within these assumptions. The bench places the ring at an aligned base and changes the buffer size and strip option only between frames, when the block is idle. Its memory model answers reads with a single register stage. The random frames, with lengths from 1 to 300 bytes and buffer sizes of 64, 128 or 1536 bytes, often spill across the wrap descriptor and back into descriptors still owned from the same frame. This drives both the mid-frame drop path and the wrap path repeatedly.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

  localparam int LEN_W      = 14;
  localparam int UNIT_W     = 8;
  localparam int UNIT_SHIFT = 6;
  localparam int DESC_STEP  = 8;
  localparam int STAT_OFS   = 4;
  localparam int FCS_BYTES  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_DATA, ST_WSTAT, ST_WOWN, ST_DROP
  } rdr_state_e;

  // Status word: length in [13:0], start flag bit 14, end flag bit 15.
  function automatic logic [31:0] stat_word(input logic sof, input logic eof,
                                            input logic [LEN_W-1:0] len);
    return {16'h0000, eof, sof, len};
  endfunction

  // Address word handed back to software: same buffer bits, wrap kept, owned.
  function automatic logic [31:0] own_word(input logic [29:0] buf_hi,
                                           input logic wrap);
    return {buf_hi, wrap, 1'b1};
  endfunction

  function automatic logic [LEN_W-1:0] rec_len(input logic [LEN_W-1:0] total,
                                               input logic strip);
    if (!strip) return total;
    return (total > LEN_W'(FCS_BYTES)) ? total - LEN_W'(FCS_BYTES) : '0;
  endfunction

  function automatic logic [LEN_W-1:0] buf_limit(input logic [UNIT_W-1:0] units);
    logic [LEN_W-1:0] u;
    u = LEN_W'(units);
    if (u == '0) u = LEN_W'(1);
    return u << UNIT_SHIFT;
  endfunction

  function automatic logic [3:0] lane_enable(input logic [1:0] lane);
    return 4'b0001 << lane;
  endfunction

endpackage

// File: rtl/rdr_ring_ptr.sv
module rdr_ring_ptr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      base_q <= '0;
    end else if (load) begin
      ptr    <= base;
      base_q <= base;
    end else if (advance) begin
      ptr <= wrap ? base_q : ptr + ADDR_W'(STEP);
    end
  end
endmodule

// File: rtl/rdr_fill_ctr.sv
module rdr_fill_ctr #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_frame,
  input  logic             clr_buf,
  input  logic             inc,
  input  logic [LEN_W-1:0] limit,
  output logic [LEN_W-1:0] off,
  output logic [LEN_W-1:0] total,
  output logic             buf_full_next
);
  assign buf_full_next = (off + LEN_W'(1)) == limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off   <= '0;
      total <= '0;
    end else begin
      if (clr_frame)      total <= '0;
      else if (inc && total != '1) total <= total + LEN_W'(1);
      if (clr_buf)        off <= '0;
      else if (inc)       off <= off + LEN_W'(1);
    end
  end
endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer
  import rdr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [UNIT_W-1:0] buf_units,
  input  logic              strip_fcs,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_sof,
  input  logic              s_eof,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              nobuf
);
  localparam int BUF_HI_W = ADDR_W - 2;

  rdr_state_e          st;
  logic                armed, first_q, last_q, wrap_q;
  logic [BUF_HI_W-1:0] buf_q;
  logic [ADDR_W-1:0]   ptr, base_q, byte_addr;
  logic [LEN_W-1:0]    off, total, limit;
  logic                buf_full_next, accept;

  // Named events, also observed by the bound checker.
  logic st_idle, load_evt, start_evt, drop_evt, take_evt, adv_evt;

  assign st_idle   = (st == ST_IDLE);
  assign load_evt  = st_idle && rx_enable && !armed;
  assign start_evt = st_idle && rx_enable && armed && s_valid && s_sof;
  assign drop_evt  = (st == ST_CHECK) && mem_rdata[0];
  assign take_evt  = (st == ST_CHECK) && !mem_rdata[0];
  assign adv_evt   = (st == ST_WOWN);
  assign limit     = buf_limit(buf_units);
  assign accept    = s_valid && s_ready;
  assign byte_addr = {buf_q, 2'b00} + ADDR_W'(off);

  always_comb begin
    unique case (st)
      ST_IDLE:         s_ready = rx_enable && armed && !s_sof;
      ST_DATA, ST_DROP: s_ready = 1'b1;
      default:         s_ready = 1'b0;
    endcase
  end

  rdr_ring_ptr #(.ADDR_W(ADDR_W), .STEP(DESC_STEP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .base(ring_base),
    .advance(adv_evt), .wrap(wrap_q), .ptr(ptr), .base_q(base_q)
  );

  rdr_fill_ctr #(.LEN_W(LEN_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr_frame(start_evt), .clr_buf(take_evt),
    .inc((st == ST_DATA) && accept), .limit(limit), .off(off),
    .total(total), .buf_full_next(buf_full_next)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_be    = 4'h0;
    mem_wdata = '0;
    unique case (st)
      ST_FETCH: mem_req = 1'b1;
      ST_DATA: begin
        mem_req   = accept;
        mem_we    = 1'b1;
        mem_addr  = {byte_addr[ADDR_W-1:2], 2'b00};
        mem_be    = lane_enable(byte_addr[1:0]);
        mem_wdata = {4{s_data}};
      end
      ST_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr + ADDR_W'(STAT_OFS);
        mem_be    = 4'hF;
        mem_wdata = stat_word(first_q, last_q,
                              last_q ? rec_len(total, strip_fcs) : off);
      end
      ST_WOWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_wdata = own_word(buf_q, wrap_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      armed   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      wrap_q  <= 1'b0;
      buf_q   <= '0;
      nobuf   <= 1'b0;
    end else begin
      nobuf <= drop_evt;
      unique case (st)
        ST_IDLE: begin
          if (!rx_enable)  armed <= 1'b0;
          else if (!armed) armed <= 1'b1;
          if (start_evt) begin
            first_q <= 1'b1;
            st      <= ST_FETCH;
          end
        end
        ST_FETCH: st <= ST_CHECK;
        ST_CHECK: begin
          if (mem_rdata[0]) st <= ST_DROP;
          else begin
            buf_q  <= mem_rdata[ADDR_W-1:2];
            wrap_q <= mem_rdata[1];
            st     <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (s_valid && s_eof) begin
            last_q <= 1'b1;
            st     <= ST_WSTAT;
          end else if (s_valid && buf_full_next) begin
            last_q <= 1'b0;
            st     <= ST_WSTAT;
          end
        end
        ST_WSTAT: st <= ST_WOWN;
        ST_WOWN: begin
          first_q <= 1'b0;
          st      <= last_q ? ST_IDLE : ST_FETCH;
        end
        ST_DROP: if (s_valid && s_eof) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdr_chk.sv
module rdr_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              armed,
  input logic              s_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              nobuf,
  input logic              st_idle,
  input logic              drop_evt,
  input logic              adv_evt,
  input logic              wrap_q,
  input logic [ADDR_W-1:0] ptr,
  input logic [ADDR_W-1:0] base_q
);
  a_r1_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

  a_r1_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[2:0] == 3'b000));

  a_r2_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && !(rx_enable && armed)) |-> !s_ready);

  a_r4_status_before_own: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 4'hF && !mem_addr[2] && mem_wdata[0]) |->
      ($past(mem_req && mem_we && mem_be == 4'hF) &&
       $past(mem_addr) == mem_addr + ADDR_W'(4)));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !wrap_q) |=> (ptr == $past(ptr) + ADDR_W'(8)));

  a_r5_wrap_base: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && wrap_q) |=> (ptr == base_q));

  a_r6_nobuf_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    nobuf |-> $past(drop_evt));
endmodule

bind rx_desc_ring_writer rdr_chk #(.ADDR_W(ADDR_W)) u_rdr_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .armed(armed),
  .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .nobuf(nobuf), .st_idle(st_idle), .drop_evt(drop_evt),
  .adv_evt(adv_evt), .wrap_q(wrap_q), .ptr(ptr), .base_q(base_q)
);

// File: tb/rx_desc_ring_writer_tb_top.sv
module rx_desc_ring_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic [7:0]  buf_units = 8'd24;
  logic        strip_fcs = 1'b0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        s_ready, mem_req, mem_we, nobuf;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  always #5 clk = ~clk;

  rx_desc_ring_writer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
    .buf_units(buf_units), .strip_fcs(strip_fcs), .s_valid(s_valid),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .nobuf(nobuf)
  );

  logic [31:0] mem [0:4095];
  logic [31:0] w0 [0:3];
  logic [7:0]  pay [0:4095];
  int n_chk = 0, n_fail = 0, nobuf_cnt = 0, wr_cnt = 0, cyc = 0, mptr = 0;

  always @(posedge clk) begin
    cyc++;
    if (nobuf) nobuf_cnt++;
    if (mem_req && mem_we) begin
      wr_cnt++;
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] = mem_wdata[8*b +: 8];
    end
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[13:2]];
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int lim_of(input logic [7:0] u);
    return (u == 8'd0) ? 64 : int'(u) * 64;
  endfunction

  function automatic logic [7:0] getb(input int a);
    logic [31:0] w;
    w = mem[a >> 2];
    return w[8*(a%4) +: 8];
  endfunction

  function automatic int dword(input int i);
    return (32'h100 + 8 * i) >> 2;
  endfunction

  task automatic push(input logic [7:0] d, input bit sof, input bit eof);
    bit r;
    s_valid = 1'b1; s_data = d; s_sof = sof; s_eof = eof;
    forever begin
      #1 r = s_ready;
      @(negedge clk);
      if (r) break;
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic run_frame(input int len, input string tag);
    int lim, idx, rem, pos, nch, nb0, c, elen;
    bit dropx;
    bit own_m [4];
    int ch_idx [8], ch_len [8], ch_pos [8];
    bit ch_first [8], ch_last [8];
    lim = lim_of(buf_units);
    for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    for (int i = 0; i < 4; i++) own_m[i] = mem[dword(i)][0];
    idx = mptr; rem = len; pos = 0; nch = 0; dropx = 0;
    while (1) begin
      if (own_m[idx]) begin dropx = 1; break; end
      c = (rem < lim) ? rem : lim;
      ch_idx[nch] = idx; ch_len[nch] = c; ch_pos[nch] = pos;
      ch_first[nch] = (nch == 0); ch_last[nch] = (rem == c);
      nch++; own_m[idx] = 1; rem -= c; pos += c;
      idx = (idx == 3) ? 0 : idx + 1;
      if (rem == 0) break;
    end
    nb0 = nobuf_cnt;
    for (int i = 0; i < len; i++) push(pay[i], i == 0, i == len - 1);
    repeat (4) @(negedge clk);
    for (int k = 0; k < nch; k++) begin
      int bad, a0;
      logic [31:0] est;
      elen = ch_last[k] ? (strip_fcs ? ((len > 4) ? len - 4 : 0) : len) : ch_len[k];
      est = {16'h0, ch_last[k], ch_first[k], 14'(elen)};
      chk(mem[dword(ch_idx[k]) + 1] == est, {tag, " R3 R8 status"},
          64'(mem[dword(ch_idx[k]) + 1]), 64'(est));
      chk(mem[dword(ch_idx[k])] == (w0[ch_idx[k]] | 32'h1), {tag, " R4 R5 own word"},
          64'(mem[dword(ch_idx[k])]), 64'(w0[ch_idx[k]] | 32'h1));
      bad = 0;
      a0 = int'(w0[ch_idx[k]] & 32'hFFFF_FFFC);
      for (int j = 0; j < ch_len[k]; j++)
        if (getb(a0 + j) != pay[ch_pos[k] + j]) bad++;
      chk(bad == 0, {tag, " R1 data bytes"}, 64'(bad), 64'd0);
    end
    chk((nobuf_cnt - nb0) == int'(dropx), {tag, " R6 R11 nobuf"},
        64'(nobuf_cnt - nb0), 64'(dropx));
    for (int k = 0; k < nch; k++) begin
      mem[dword(ch_idx[k])] = w0[ch_idx[k]];
      mem[dword(ch_idx[k]) + 1] = 32'h0;
    end
    mptr = idx;
  endtask

  initial begin
    int wr0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    for (int i = 0; i < 4; i++) begin
      w0[i] = 32'h1000 + 32'h800 * i + ((i == 3) ? 32'h2 : 32'h0);
      mem[dword(i)] = w0[i];
    end
    repeat (3) @(negedge clk);
    chk(s_ready == 0 && mem_req == 0 && nobuf == 0, "R2 reset state",
        64'({s_ready, mem_req, nobuf}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: disabled, a start byte must not be taken and memory stays untouched
    s_valid = 1'b1; s_sof = 1'b1;
    wr0 = wr_cnt;
    for (int i = 0; i < 5; i++) begin
      #1 chk(s_ready == 0 && mem_req == 0, "R2 disabled", 64'({s_ready, mem_req}), 64'd0);
      @(negedge clk);
    end
    s_valid = 1'b0; s_sof = 1'b0;
    chk(wr_cnt == wr0, "R2 no writes while disabled", 64'(wr_cnt), 64'(wr0));
    rx_enable = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(60, "R1 first frame at base");
    strip_fcs = 1'b1;
    run_frame(64, "R9 strip");
    run_frame(3, "R9 strip floor");
    strip_fcs = 1'b0;
    run_frame(10, "R5 wrap descriptor");
    run_frame(12, "R5 after wrap");
    // R6: owned descriptor at frame start
    mem[dword(mptr)] = w0[mptr] | 32'h1;
    run_frame(40, "R6 owned at start");
    mem[dword(mptr)] = w0[mptr];
    run_frame(20, "R6 same descriptor reused");
    buf_units = 8'd1;
    run_frame(64, "R7 exact fit");
    run_frame(65, "R8 spill by one");
    run_frame(200, "R8 R5 spill across wrap");
    buf_units = 8'd0;
    run_frame(100, "R7 zero units");
    // R11: follow-on descriptor owned mid-frame
    buf_units = 8'd1;
    begin
      int nxt;
      nxt = (mptr == 3) ? 0 : mptr + 1;
      mem[dword(nxt)] = w0[nxt] | 32'h1;
      run_frame(150, "R11 mid-frame owned");
      mem[dword(nxt)] = w0[nxt];
    end
    run_frame(8, "R11 pointer stayed");
    // R10: stray byte without start marker
    wr0 = wr_cnt;
    push(8'hA5, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(wr_cnt == wr0, "R10 stray byte no write", 64'(wr_cnt), 64'(wr0));
    run_frame(16, "R10 next frame");
    for (int n = 0; n < 40; n++) begin
      int sel;
      sel = int'($urandom_range(0, 2));
      buf_units = (sel == 0) ? 8'd1 : ((sel == 1) ? 8'd2 : 8'd24);
      strip_fcs = 1'($urandom_range(0, 1));
      run_frame(int'($urandom_range(1, 300)), "R8 R9 random");
      for (int i = 0; i < 4; i++) begin
        mem[dword(i)] = w0[i];
        mem[dword(i) + 1] = 32'h0;
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule